// File: doc/BRIEF.md
# Peak Current Limit Latch for a Dual Half-Bridge

This block guards two half-bridge phases against excessive peak current. Each phase delivers a single bit from an external high-side current comparator that goes high whenever that phase's current is above the allowed peak. The comparator bits are asynchronous to the clock, so they are synchronized first. Once either bit is seen high, the block latches a limit condition. While the condition holds, it asserts a global disable that turns off every output transistor in both phases, and it raises a limit status output.

Release is tied to the PWM pattern and not to a timer. The block remembers which phase or phases caused the trip. It re-arms only once every comparator bit is low again and the top-side command of every recorded phase is low. After it has re-armed, the next rising edge on either phase's top-side command clears the latch. Under normal commutation this yields one limit event per PWM period at most.

A host-driven enable can switch the function off completely. While the enable is low, the outputs stay inactive and the bridge follows its PWM commands alone.

Top module: `curlim_latch`

## Requirements
- R1: Comparator bits pass through a two-flop synchronizer. With the enable high, a comparator bit that is set up before a clock edge makes `limit_o` high after the third clock edge, counting that edge as the first.
- R2: A high comparator bit on either phase (bit 0 is phase 0, bit 1 is phase 1) sets the latch. This drives `limit_o` high and `dis_o` high, and `dis_o` disables the output transistors of both phases.
- R3: `dis_o` always equals `limit_o`. Both are low after reset and in normal operation.
- R4: While any synchronized comparator bit is high, the latch stays set. A new trip while the latch is re-armed cancels the re-arm.
- R5: The latch re-arms only when all comparator bits are low and the top command of every recorded phase is low. It never clears while a comparator bit is high.
- R6: When both phases trip, both are recorded. A recorded phase whose top command stays high blocks the re-arm, even if the other phase's top command toggles.
- R7: After re-arming, a rising edge on either top command clears the latch. `limit_o` falls after the third clock edge following the top command's rise, because the command is synchronized over two flops.
- R8: A top-command rising edge that arrives before the re-arm conditions hold, or in the same cycle in which they first hold, is ignored.
- R9: Top commands held constantly high or constantly low produce no rising edge, so a set latch stays set.
- R10: The limit enable `lim_en_i` is synchronous to the clock. While it is low, the latch is cleared and the recorded phases are forgotten at the next edge, and comparator bits have no effect on `limit_o` or `dis_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| over_i | input | NPH | Asynchronous per-phase over-threshold bits |
| top_i | input | NPH | Per-phase top-side PWM commands |
| lim_en_i | input | 1 | Current-limit function enable |
| limit_o | output | 1 | Limit engaged status |
| dis_o | output | 1 | Global disable for all output transistors |

## Verification
On every cycle, the assertions check the following: a synchronized trip always sets the latch, a low enable always clears it, the latch never drops without a synchronized top-command rising edge, and it never drops while a comparator bit was high. Some behaviours are visible only in the bench scenarios. These include the phase-record rule for simultaneous trips, the rejection of an edge that coincides with the re-arm moment, and the exact three-edge latency through the synchronizers.

// File: rtl/curlim_pkg.sv
package curlim_pkg;
  typedef enum logic [1:0] {
    LIM_RUN   = 2'd0,
    LIM_HOLD  = 2'd1,
    LIM_ARMED = 2'd2
  } lim_state_e;
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cl_rise.sv
module cl_rise #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/cl_latch.sv
module cl_latch
  import curlim_pkg::*;
#(
  parameter int unsigned NPH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [NPH-1:0] ov_i,
  input  logic [NPH-1:0] top_i,
  input  logic [NPH-1:0] rise_i,
  output logic           lim_o
);
  lim_state_e     st_q;
  logic [NPH-1:0] cul_q;
  logic           cul_low;

  // every recorded phase must have its top command low
  assign cul_low = ~|(cul_q & top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LIM_RUN;
      cul_q <= '0;
    end else if (!en_i) begin
      st_q  <= LIM_RUN;
      cul_q <= '0;
    end else if (|ov_i) begin
      st_q  <= LIM_HOLD;
      cul_q <= cul_q | ov_i;
    end else begin
      unique case (st_q)
        LIM_HOLD:  if (cul_low) st_q <= LIM_ARMED;
        LIM_ARMED: if (|rise_i) begin
          st_q  <= LIM_RUN;
          cul_q <= '0;
        end
        default:   st_q <= LIM_RUN;
      endcase
    end
  end

  assign lim_o = (st_q != LIM_RUN);
endmodule

// File: rtl/curlim_latch.sv
module curlim_latch #(
  parameter int unsigned NPH         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] over_i,
  input  logic [NPH-1:0] top_i,
  input  logic           lim_en_i,
  output logic           limit_o,
  output logic           dis_o
);
  logic [NPH-1:0] ov_s;
  logic [NPH-1:0] top_s;
  logic [NPH-1:0] top_rise;
  logic           lim;

  cl_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync_ov (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(over_i), .q_o(ov_s)
  );

  cl_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(top_i), .q_o(top_s)
  );

  cl_rise #(.W(NPH)) u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(top_s), .rise_o(top_rise)
  );

  cl_latch #(.NPH(NPH)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lim_en_i),
    .ov_i(ov_s), .top_i(top_s), .rise_i(top_rise), .lim_o(lim)
  );

  assign limit_o = lim;
  assign dis_o   = lim;
endmodule

// File: rtl/curlim_latch_chk.sv
module curlim_latch_chk #(
  parameter int unsigned NPH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic [NPH-1:0] ov_s,
  input logic [NPH-1:0] top_s,
  input logic           limit_o,
  input logic           dis_o
);
  logic [NPH-1:0] top_prev;
  logic           any_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_prev <= '0;
    else top_prev <= top_s;
  end

  assign any_rise = |(top_s & ~top_prev);

  assert_trip_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && |ov_s) |=> (limit_o && dis_o));

  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!limit_o && !dis_o));

  assert_hold_without_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_o && en_i && !any_rise) |=> limit_o);

  assert_no_release_over_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_o && en_i && |ov_s) |=> limit_o);
endmodule

bind curlim_latch curlim_latch_chk #(.NPH(NPH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lim_en_i), .ov_s(ov_s),
  .top_s(top_s), .limit_o(limit_o), .dis_o(dis_o)
);

// File: tb/tb_curlim_latch.sv
module tb_curlim_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] over = 2'b00;
  logic [1:0] top = 2'b00;
  logic       en = 1'b0;
  logic       limit, dis;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  // reference state, built from the requirements
  logic [1:0] m_ov1, m_ov2, m_t1, m_t2, m_tq, m_cul;
  logic       m_hold, m_arm;

  always #2.5 clk = ~clk;

  curlim_latch dut (
    .clk_i(clk), .rst_ni(rst_n), .over_i(over), .top_i(top),
    .lim_en_i(en), .limit_o(limit), .dis_o(dis)
  );

  function automatic logic cul_clear(logic [1:0] cul, logic [1:0] ts);
    return (cul & ts) == 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov1 <= 0; m_ov2 <= 0; m_t1 <= 0; m_t2 <= 0; m_tq <= 0;
      m_cul <= 0; m_hold <= 0; m_arm <= 0;
    end else begin
      m_ov1 <= over; m_ov2 <= m_ov1; m_t1 <= top; m_t2 <= m_t1; m_tq <= m_t2;
      if (!en) begin
        m_hold <= 0; m_arm <= 0; m_cul <= 0;
      end else if (|m_ov2) begin
        m_hold <= 1; m_arm <= 0; m_cul <= m_cul | m_ov2;
      end else if (m_hold && !m_arm) begin
        if (cul_clear(m_cul, m_t2)) m_arm <= 1;
      end else if (m_arm && |(m_t2 & ~m_tq)) begin
        m_hold <= 0; m_arm <= 0; m_cul <= 0;
      end
    end
  end

  task automatic chk(string req, logic exp_lim);
    checks++;
    if (limit !== exp_lim || dis !== exp_lim) begin
      errors++;
      $display("FAIL %s limit=%b dis=%b expected=%b", req, limit, dis, exp_lim);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog limit=%b expected=done", limit);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    step(2);
    chk("R3 reset", 1'b0);
    rst_n = 1'b1; en = 1'b1;
    step(2);
    chk("R3 idle", 1'b0);

    // R1: three-edge trip latency, phase 0
    over = 2'b01;
    step(2); chk("R1 not yet", 1'b0);
    step(1); chk("R1 R2 set", 1'b1);
    over = 2'b00;
    step(6); chk("R9 tops low stays", 1'b1);
    // R7: other phase rise releases
    top = 2'b10;
    step(2); chk("R7 before edge", 1'b1);
    step(1); chk("R7 released", 1'b0);
    top = 2'b00; step(4);

    // R6: both trip with both tops high
    top = 2'b11; over = 2'b11; step(4);
    chk("R6 set", 1'b1);
    over = 2'b00; top = 2'b10; step(5);
    top = 2'b11; step(1); top = 2'b10; step(5);
    chk("R6 phase1 top high blocks", 1'b1);
    top = 2'b00; step(5);
    top = 2'b01; step(3);
    chk("R6 released", 1'b0);
    top = 2'b00; step(4);

    // R8: rise in the same cycle the conditions first hold
    top = 2'b01; over = 2'b01; step(4);
    over = 2'b00; step(4);
    top = 2'b10; step(6);
    chk("R8 coincident edge ignored", 1'b1);
    top = 2'b00; step(4);
    top = 2'b10; step(3);
    chk("R8 later edge releases", 1'b0);
    top = 2'b00; step(4);

    // R4: re-trip while armed cancels re-arm
    over = 2'b10; step(4); over = 2'b00; step(4);
    over = 2'b10; step(1); top = 2'b01; step(3);
    chk("R4 held while over", 1'b1);
    over = 2'b00; step(6);
    chk("R5 edge during over ignored", 1'b1);
    top = 2'b00; step(3); top = 2'b01; step(3);
    chk("R5 release after rearm", 1'b0);
    top = 2'b00; step(4);

    // R10: enable low clears and masks
    over = 2'b01; step(4); chk("R10 pre set", 1'b1);
    en = 1'b0; step(1); chk("R10 cleared", 1'b0);
    step(5); chk("R10 over masked", 1'b0);
    over = 2'b00; step(3); en = 1'b1; step(3);
    chk("R10 re-enabled idle", 1'b0);

    // random PWM and trips against the reference
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) top = 2'($urandom);
      if ($urandom_range(0, 15) == 0) over = 2'($urandom);
      else if ($urandom_range(0, 3) == 0) over = 2'b00;
      en = ($urandom_range(0, 99) != 0);
      step(1);
      chk("R2 R5 R7 random", m_hold);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule